// File: doc/BRIEF.md
# Packed BCD Decimal Corrector

This block adds two packed-decimal operands and returns a correct decimal sum. Each operand holds four decimal digits of four bits each. A single carry-in feeds the lowest digit. Each digit pair is added in binary together with the carry from the digit below it. A digit whose raw sum is above nine is corrected by adding six. The corrected digit keeps its low four bits and sends a carry to the next digit up. The carry out of the top digit leaves the block on its own output.

While the add takes place, every nibble of both operands is also checked. If any nibble holds a code from ten to fifteen, the overflow flag is raised. The result lanes are not forced to any special value in that case. They hold the same per-digit correction, applied to the raw nibbles, so the output is always deterministic.

The adder itself is combinational. A parameter selects whether the three outputs pass through a single output register or drive the ports directly.

Top module: `bcd_corrector`

## Requirements
- R1: When every nibble of both operands is 0..9, `sum_o` is the packed-decimal encoding (digit i in bits 4i+3..4i) of (A + B + carry_in) modulo 10^DIGITS, where A and B are the decimal values of the operands.
- R2: When every source nibble is 0..9, `carry_o` is 1 exactly when A + B + carry_in is at least 10^DIGITS.
- R3: A digit whose binary sum, including the incoming digit carry, exceeds 9 is corrected by adding six, and a carry passes into the next digit (for example 0x0009+0x0001 gives 0x0010, and 0x0999+0x0001 gives 0x1000).
- R4: `carry_in` adds one to the least significant digit, and that one ripples through a run of 9 digits (0x9999+0x0000 with carry_in=1 gives 0x0000 with carry_o=1).
- R5: `bad_digit_o` is 1 if and only if at least one nibble of either operand holds a code from 10 to 15.
- R6: For any nibbles, including invalid ones, digit i works as follows. Take s = a_i + b_i + c_i. If s > 9, the result digit is (s + 6) mod 16 and the carry c_(i+1) is 1. Otherwise the result digit is s and the carry is 0. For example, 0x00FF+0x00FF gives 0x0154, and 0xA000+0x0000 gives 0x0000 with carry_o=1.
- R7: The top carry is never merged into the overflow flag. For example, 0x5000+0x5000 gives 0x0000 with carry_o=1 and bad_digit_o=0.
- R8: With REGISTER_OUT=1, all outputs show the result of the inputs present at the previous rising clock edge, and an active-low reset drives every output to zero. With REGISTER_OUT=0, the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| opnd_a | input | 4*DIGITS | First packed-decimal operand |
| opnd_b | input | 4*DIGITS | Second packed-decimal operand |
| carry_in | input | 1 | Carry into the least significant digit |
| sum_o | output | 4*DIGITS | Corrected packed-decimal sum |
| carry_o | output | 1 | Decimal carry out of the most significant digit |
| bad_digit_o | output | 1 | Set when any source nibble is above 9 |

## Verification
The bench builds two copies of the block, both with DIGITS=4. One uses REGISTER_OUT=1, and its results are compared one clock after each drive. The other uses REGISTER_OUT=0, and its results are compared in the same cycle. Between them they exercise both sides of the generate choice, along with the reset value and the one-cycle latency. Four digits keep the decimal range small enough that random operands often reach the carry-out boundary, full ripple chains of nines, and every invalid nibble code.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

   localparam int NIB_W = 4;
   localparam int MAX_DEC = 9;
   localparam int FIX_ADD = 6;

   typedef logic [NIB_W-1:0] nibble_t;

   typedef struct packed {
      nibble_t digit;
      logic    carry;
   } digit_res_t;

endpackage

// File: rtl/bcd_digit_check.sv
module bcd_digit_check
   import bcd_pkg::*;
(
   input  nibble_t nib,
   output logic    is_dec
);

   always_comb begin
      is_dec = (nib <= nibble_t'(MAX_DEC));
   end

endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
   import bcd_pkg::*;
(
   input  nibble_t    a,
   input  nibble_t    b,
   input  logic       cin,
   output digit_res_t res
);

   logic [NIB_W:0] raw;
   logic [NIB_W:0] adj;
   logic           fix;

   always_comb begin
      raw = {1'b0, a} + {1'b0, b} + {{NIB_W{1'b0}}, cin};
      fix = (raw > (NIB_W+1)'(MAX_DEC));
      adj = raw + (NIB_W+1)'(FIX_ADD);
      res.digit = fix ? adj[NIB_W-1:0] : raw[NIB_W-1:0];
      res.carry = fix;
   end

endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage #(
   parameter int W = 18,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (REGISTER_OUT) begin : g_reg
         logic [W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d;
         end
         assign q = q_r;
      end else begin : g_pass
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/bcd_corrector.sv
module bcd_corrector
   import bcd_pkg::*;
#(
   parameter int DIGITS = 4,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DIGITS*4-1:0]   opnd_a,
   input  logic [DIGITS*4-1:0]   opnd_b,
   input  logic                  carry_in,
   output logic [DIGITS*4-1:0]   sum_o,
   output logic                  carry_o,
   output logic                  bad_digit_o
);

   localparam int W = DIGITS * NIB_W;
   localparam int OUT_W = W + 2;

   generate
      if (DIGITS < 1) begin : g_bad_digits
         $error("bcd_corrector: DIGITS must be at least 1");
      end
      if (DIGITS > 16) begin : g_too_wide
         $error("bcd_corrector: DIGITS above 16 is not supported");
      end
   endgenerate

   logic [DIGITS:0]   chain;
   logic [W-1:0]      sum_c;
   logic [DIGITS-1:0] ok_a;
   logic [DIGITS-1:0] ok_b;
   logic              bad_c;
   logic [OUT_W-1:0]  pack_d;
   logic [OUT_W-1:0]  pack_q;

   assign chain[0] = carry_in;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
         digit_res_t r;
         bcd_digit_add u_add (
            .a   (opnd_a[i*NIB_W +: NIB_W]),
            .b   (opnd_b[i*NIB_W +: NIB_W]),
            .cin (chain[i]),
            .res (r)
         );
         assign sum_c[i*NIB_W +: NIB_W] = r.digit;
         assign chain[i+1] = r.carry;

         bcd_digit_check u_chk_a (
            .nib    (opnd_a[i*NIB_W +: NIB_W]),
            .is_dec (ok_a[i])
         );
         bcd_digit_check u_chk_b (
            .nib    (opnd_b[i*NIB_W +: NIB_W]),
            .is_dec (ok_b[i])
         );
      end
   endgenerate

   assign bad_c  = ~(&ok_a & &ok_b);
   assign pack_d = {bad_c, chain[DIGITS], sum_c};

   bcd_out_stage #(.W(OUT_W), .REGISTER_OUT(REGISTER_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pack_d),
      .q     (pack_q)
   );

   assign sum_o       = pack_q[W-1:0];
   assign carry_o     = pack_q[W];
   assign bad_digit_o = pack_q[W+1];

endmodule

// File: rtl/bcd_corrector_chk.sv
module bcd_corrector_chk #(
   parameter int DIGITS = 4,
   parameter bit REGISTER_OUT = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [DIGITS*4-1:0] opnd_a,
   input logic [DIGITS*4-1:0] opnd_b,
   input logic                carry_in,
   input logic [DIGITS*4-1:0] sum_o,
   input logic                carry_o,
   input logic                bad_digit_o
);

   localparam int W = DIGITS * 4;

   logic [W-1:0] in_a, in_b;
   logic         in_c;
   logic         primed;

   generate
      if (REGISTER_OUT) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_a <= '0; in_b <= '0; in_c <= 1'b0; primed <= 1'b0;
            end else begin
               in_a <= opnd_a; in_b <= opnd_b; in_c <= carry_in; primed <= 1'b1;
            end
         end
      end else begin : g_now
         assign in_a = opnd_a;
         assign in_b = opnd_b;
         assign in_c = carry_in;
         assign primed = 1'b1;
      end
   endgenerate

   function automatic bit all_dec(input logic [W-1:0] v);
      bit ok = 1'b1;
      for (int i = 0; i < DIGITS; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   function automatic longint dec_val(input logic [W-1:0] v);
      longint acc = 0;
      for (int i = DIGITS-1; i >= 0; i--) acc = acc * 10 + longint'(v[i*4 +: 4]);
      return acc;
   endfunction

   function automatic longint dec_lim();
      longint p = 1;
      for (int i = 0; i < DIGITS; i++) p = p * 10;
      return p;
   endfunction

   logic   src_ok;
   longint total;
   assign src_ok = all_dec(in_a) && all_dec(in_b);
   assign total  = dec_val(in_a) + dec_val(in_b) + longint'(in_c);

   // R5
   bad_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (bad_digit_o == !src_ok));

   // R1
   sum_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && src_ok) |-> (dec_val(sum_o) == (total % dec_lim())));

   // R2
   carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && src_ok) |-> (carry_o == (total >= dec_lim())));

   // R3
   digits_decimal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !bad_digit_o) |-> all_dec(sum_o));

endmodule

bind bcd_corrector bcd_corrector_chk #(.DIGITS(DIGITS), .REGISTER_OUT(REGISTER_OUT)) u_bcd_chk (
   .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
   .sum_o(sum_o), .carry_o(carry_o), .bad_digit_o(bad_digit_o)
);

// File: tb/tb_bcd_corrector.sv
`timescale 1ns/1ps
module tb_bcd_corrector;

   localparam int DG = 4;
   localparam int W = DG * 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] a = '0, b = '0;
   logic cin = 1'b0;
   logic [W-1:0] s_r, s_c;
   logic cy_r, cy_c, bd_r, bd_c;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic [W-1:0] res;
      logic         cy;
      logic         bad;
      string        tag;
   } exp_t;

   exp_t sb[$];

   always #4 clk = ~clk;

   bcd_corrector #(.DIGITS(DG), .REGISTER_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b), .carry_in(cin),
      .sum_o(s_r), .carry_o(cy_r), .bad_digit_o(bd_r));

   bcd_corrector #(.DIGITS(DG), .REGISTER_OUT(1'b0)) dut_comb (
      .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b), .carry_in(cin),
      .sum_o(s_c), .carry_o(cy_c), .bad_digit_o(bd_c));

   function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                  input logic c, input string tag);
      exp_t e;
      bit ok = 1'b1;
      int xv = 0, yv = 0, tot, rem;
      for (int i = 0; i < DG; i++)
         if (x[i*4 +: 4] > 9 || y[i*4 +: 4] > 9) ok = 1'b0;
      e.tag = tag;
      e.bad = !ok;
      if (ok) begin
         for (int i = DG-1; i >= 0; i--) begin
            xv = xv * 10 + int'(x[i*4 +: 4]);
            yv = yv * 10 + int'(y[i*4 +: 4]);
         end
         tot = xv + yv + int'(c);
         e.cy = (tot >= 10000);
         rem = tot % 10000;
         for (int i = 0; i < DG; i++) begin
            e.res[i*4 +: 4] = 4'(rem % 10);
            rem = rem / 10;
         end
      end else begin
         int k = int'(c);
         for (int i = 0; i < DG; i++) begin
            int sd = int'(x[i*4 +: 4]) + int'(y[i*4 +: 4]) + k;
            if (sd > 9) begin e.res[i*4 +: 4] = 4'((sd + 6) % 16); k = 1; end
            else        begin e.res[i*4 +: 4] = 4'(sd);            k = 0; end
         end
         e.cy = (k == 1);
      end
      return e;
   endfunction

   task automatic compare(input string who, input exp_t e, input logic [W-1:0] rs,
                          input logic rc, input logic rb);
      n_chk++;
      if (rs !== e.res || rc !== e.cy || rb !== e.bad) begin
         n_fail++;
         $display("FAIL %s %s: got sum=%h cy=%b bad=%b expected sum=%h cy=%b bad=%b",
                  e.tag, who, rs, rc, rb, e.res, e.cy, e.bad);
      end
   endtask

   task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic c, input string tag);
      exp_t e;
      e = model(x, y, c, tag);
      @(negedge clk);
      a = x; b = y; cin = c;
      #1;
      compare("R8 comb", e, s_c, cy_c, bd_c);
      sb.push_back(e);
   endtask

   always @(posedge clk) begin
      #2;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         compare("R8 reg", e, s_r, cy_r, bd_r);
      end
   end

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      a = 16'h1111; b = 16'h2222; cin = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (s_r !== '0 || cy_r !== 1'b0 || bd_r !== 1'b0) begin
         n_fail++;
         $display("FAIL R8 reset: got sum=%h cy=%b bad=%b expected 0000 0 0", s_r, cy_r, bd_r);
      end
      rst_n = 1'b1;

      drive(16'h1234, 16'h4321, 1'b0, "R1");
      drive(16'h0009, 16'h0001, 1'b0, "R3");
      drive(16'h0999, 16'h0001, 1'b0, "R3");
      drive(16'h0000, 16'h0000, 1'b1, "R4");
      drive(16'h9999, 16'h0000, 1'b1, "R4");
      drive(16'h9999, 16'h9999, 1'b1, "R2");
      drive(16'h5000, 16'h5000, 1'b0, "R7");
      drive(16'h000F, 16'h0000, 1'b0, "R5");
      drive(16'h0000, 16'hB000, 1'b0, "R5");
      drive(16'h00FF, 16'h00FF, 1'b0, "R6");
      drive(16'hA000, 16'h0000, 1'b0, "R6");

      for (int n = 0; n < 300; n++) begin
         logic [W-1:0] x, y;
         for (int i = 0; i < DG; i++) begin
            x[i*4 +: 4] = 4'($urandom_range(0, 9));
            y[i*4 +: 4] = 4'($urandom_range(0, 9));
         end
         drive(x, y, 1'($urandom_range(0, 1)), "R1");
      end
      for (int n = 0; n < 100; n++) begin
         drive(16'($urandom), 16'($urandom), 1'($urandom_range(0, 1)), "R6");
      end

      repeat (3) @(posedge clk);
      #3;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule